// File: doc/BRIEF.md
# Gain-Switching Pixel Calibration Corrector

This block sits in the readout path of an integrating pixel detector whose pixels pick one of three amplifier gains sample by sample. Each incoming raw word holds a 14-bit amplitude and a 2-bit gain code. The block looks up calibration data for that pixel and that gain code in on-chip memory and subtracts the pixel's dark level. It then removes a frame-correlated offset measured on shielded reference pixels, scales by the per-pixel gain in fixed point, and rounds to an integer photon count. That count leaves on a valid/ready stream.

The calibration contents are loaded beforehand through a write port. That port stores a dark level and a gain factor for each (pixel, gain code) pair, and a bad flag for each pixel. Pixels are addressed by a linear index. The column within a row is the index modulo the row length, and the first columns of each row act as the reference pixels that measure the common-mode offset. The pipeline accepts one pixel per cycle and stalls as one unit when the output is back-pressured.

Top module: `pixcal_top`

## Requirements
- R1: The raw word holds the amplitude in bits [13:0] and the gain code in bits [15:14]. Gain codes 0, 1 and 2 each select their own dark level and gain factor for the pixel.
- R2: A cycle with `cal_we` high stores `cal_base` and `cal_gain` for pixel `cal_idx` and gain code `cal_gsel`. A cycle with `cal_bad_we` high stores `cal_bad` as that pixel's bad flag. A later write replaces the earlier value.
- R3: The first correction step is d = amplitude - dark level of the selected gain code, as a signed value.
- R4: Columns 0 to 3 of each row (column = index mod 16) are reference pixels. When column 3 is processed, the offset becomes floor((sum of d over columns 0..3) / 4), rounded toward minus infinity. Every later pixel has that offset subtracted (c = d - offset). The offset is 0 until the first latch after reset.
- R5: Reference pixels produce the output value 0.
- R6: The gain factor is unsigned with 12 fractional bits. The result is floor((c * gain + 2048) / 4096), which rounds halves upward.
- R7: A negative result gives 0. A result above 65534 gives 65534, so a computed value never equals 65535.
- R8: A pixel whose bad flag is set, or whose gain code is 3, produces 65535.
- R9: A pixel accepted at a clock edge appears on `out_data`/`out_idx` with `out_valid` after the third edge that follows, not earlier. Pixels sent on consecutive cycles leave on consecutive cycles in the same order.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` and `out_idx` hold their values and `in_ready` is low.
- R11: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Raw pixel present |
| in_ready | output | 1 | Pixel accepted this cycle when high with in_valid |
| in_word | input | 16 | Gain code [15:14], amplitude [13:0] |
| in_idx | input | 8 | Linear pixel index |
| out_valid | output | 1 | Corrected pixel present |
| out_ready | input | 1 | Downstream accepts the corrected pixel |
| out_data | output | 16 | Photon count, 65535 marks a bad pixel |
| out_idx | output | 8 | Index of the corrected pixel |
| cal_we | input | 1 | Store dark level and gain factor |
| cal_bad_we | input | 1 | Store bad flag |
| cal_idx | input | 8 | Pixel index for calibration writes |
| cal_gsel | input | 2 | Gain code for calibration writes |
| cal_base | input | 14 | Dark level |
| cal_gain | input | 16 | Gain factor, 12 fractional bits |
| cal_bad | input | 1 | Bad flag value |

## Verification
A pixel taken on edge k is due on the output after edge k+3. Every directed scenario first confirms that nothing is valid after edge k+2, then samples the data on the falling edge after k+3. Burst pixels are read on successive falling edges, because each one trails the previous pixel by exactly one cycle. The offset latched from a row's reference pixels applies to every later pixel, so each scenario sends its reference pixels before the pixels it checks. Back-pressure is checked by holding `out_ready` low for several cycles past the due edge, then confirming that the word drains one edge after release.

// File: rtl/pixcal_pkg.sv
package pixcal_pkg;
  localparam int GSEL_W = 2;

  typedef enum logic [GSEL_W-1:0] {
    GC_G0  = 2'd0,
    GC_G1  = 2'd1,
    GC_G2  = 2'd2,
    GC_BAD = 2'd3
  } gcode_e;
endpackage

// File: rtl/pixcal_cal_store.sv
// Calibration memory: {dark, gain} per (pixel, gain code), plus one bad bit per pixel.
module pixcal_cal_store
  import pixcal_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int AMP_W  = 14,
  parameter int GAIN_W = 16
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              bad_we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [GSEL_W-1:0] wr_gsel,
  input  logic [AMP_W-1:0]  wr_base,
  input  logic [GAIN_W-1:0] wr_gain,
  input  logic              bad_val,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [GSEL_W-1:0] rd_gsel,
  output logic [AMP_W-1:0]  rd_base,
  output logic [GAIN_W-1:0] rd_gain,
  output logic              rd_bad
);
  localparam int ENT_W  = AMP_W + GAIN_W;
  localparam int DEPTH  = 1 << (IDX_W + GSEL_W);
  localparam int NPIX_L = 1 << IDX_W;

  logic [ENT_W-1:0] ent_mem [DEPTH];
  logic             bad_mem [NPIX_L];
  logic [ENT_W-1:0] ent_q;

  always_ff @(posedge clk) begin
    if (wr_en) ent_mem[{wr_idx, wr_gsel}] <= {wr_base, wr_gain};
    if (rd_en) ent_q <= ent_mem[{rd_idx, rd_gsel}];
  end

  always_ff @(posedge clk) begin
    if (bad_we) bad_mem[wr_idx] <= bad_val;
    if (rd_en)  rd_bad <= bad_mem[rd_idx];
  end

  assign rd_base = ent_q[ENT_W-1:GAIN_W];
  assign rd_gain = ent_q[GAIN_W-1:0];
endmodule

// File: rtl/pixcal_cmode.sv
// Dark subtraction and common-mode removal; owns the per-row offset state.
module pixcal_cmode #(
  parameter int AMP_W = 14,
  parameter int COL_W = 4,
  parameter int REF_N = 4,
  parameter int CORR_W = AMP_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     upd,
  input  logic [COL_W-1:0]         col,
  input  logic [AMP_W-1:0]         amp,
  input  logic [AMP_W-1:0]         base,
  output logic signed [CORR_W-1:0] corr,
  output logic                     is_ref
);
  localparam int REF_W  = $clog2(REF_N);
  localparam int DIFF_W = AMP_W + 1;
  localparam int ACC_W  = DIFF_W + REF_W;

  logic signed [DIFF_W-1:0] diff;
  logic signed [DIFF_W-1:0] cm;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  acc_sum;

  always_comb begin
    diff    = $signed({1'b0, amp}) - $signed({1'b0, base});
    is_ref  = (col < COL_W'(REF_N));
    acc_sum = (col == '0) ? ACC_W'(diff) : acc + ACC_W'(diff);
    corr    = CORR_W'(diff) - CORR_W'(cm);
  end

  // Floor mean: dropping the low bits of a two's-complement sum rounds down.
  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      cm  <= '0;
    end else if (upd && is_ref) begin
      acc <= acc_sum;
      if (col == COL_W'(REF_N - 1)) cm <= acc_sum[ACC_W-1:REF_W];
    end
  end
endmodule

// File: rtl/pixcal_round.sv
// Fixed-point to photon count: half-up rounding, clamping and marker override.
module pixcal_round #(
  parameter int CORR_W = 16,
  parameter int GAIN_W = 16,
  parameter int FRAC   = 12,
  parameter int OUT_W  = 16,
  parameter int PROD_W = CORR_W + GAIN_W + 1
) (
  input  logic signed [PROD_W-1:0] prod,
  input  logic                     bad,
  input  logic                     is_ref,
  output logic [OUT_W-1:0]         word
);
  localparam logic signed [PROD_W-1:0] HALF =
    {{(PROD_W-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
  localparam logic [OUT_W-1:0] MARKER = '1;
  localparam logic [OUT_W-1:0] SAT_V  = {{(OUT_W-1){1'b1}}, 1'b0};
  localparam logic signed [PROD_W-1:0] SAT_S = {{(PROD_W-OUT_W){1'b0}}, SAT_V};

  logic signed [PROD_W-1:0] rnd;
  logic signed [PROD_W-1:0] q;

  always_comb begin
    rnd = prod + HALF;
    q   = rnd >>> FRAC;
    if (is_ref)          word = '0;
    else if (bad)        word = MARKER;
    else if (q < 0)      word = '0;
    else if (q > SAT_S)  word = SAT_V;
    else                 word = q[OUT_W-1:0];
  end
endmodule

// File: rtl/pixcal_top.sv
module pixcal_top
  import pixcal_pkg::*;
#(
  parameter int NPIX    = 256,
  parameter int ROW_LEN = 16,
  parameter int REF_N   = 4,
  parameter int AMP_W   = 14,
  parameter int GAIN_W  = 16,
  parameter int FRAC    = 12,
  parameter int OUT_W   = 16,
  parameter int IDX_W   = $clog2(NPIX)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [AMP_W+GSEL_W-1:0]   in_word,
  input  logic [IDX_W-1:0]          in_idx,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [OUT_W-1:0]          out_data,
  output logic [IDX_W-1:0]          out_idx,
  input  logic                      cal_we,
  input  logic                      cal_bad_we,
  input  logic [IDX_W-1:0]          cal_idx,
  input  logic [GSEL_W-1:0]         cal_gsel,
  input  logic [AMP_W-1:0]          cal_base,
  input  logic [GAIN_W-1:0]         cal_gain,
  input  logic                      cal_bad
);
  localparam int COL_W  = $clog2(ROW_LEN);
  localparam int CORR_W = AMP_W + 2;
  localparam int PROD_W = CORR_W + GAIN_W + 1;

  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // Stage 1: input capture alongside the synchronous calibration read
  logic              v1;
  logic [AMP_W-1:0]  amp1;
  gcode_e            gsel1;
  logic [IDX_W-1:0]  idx1;
  logic [AMP_W-1:0]  base1;
  logic [GAIN_W-1:0] gain1;
  logic              badf1;

  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else if (adv) v1 <= in_valid;
    if (adv) begin
      amp1  <= in_word[AMP_W-1:0];
      gsel1 <= gcode_e'(in_word[AMP_W+GSEL_W-1:AMP_W]);
      idx1  <= in_idx;
    end
  end

  pixcal_cal_store #(.IDX_W(IDX_W), .AMP_W(AMP_W), .GAIN_W(GAIN_W)) u_store (
    .clk(clk), .wr_en(cal_we), .bad_we(cal_bad_we), .wr_idx(cal_idx),
    .wr_gsel(cal_gsel), .wr_base(cal_base), .wr_gain(cal_gain), .bad_val(cal_bad),
    .rd_en(adv), .rd_idx(in_idx), .rd_gsel(in_word[AMP_W+GSEL_W-1:AMP_W]),
    .rd_base(base1), .rd_gain(gain1), .rd_bad(badf1)
  );

  // Stage 2: dark and common-mode removal
  logic signed [CORR_W-1:0] corr_c;
  logic                     ref_c;
  logic                     v2, bad2, rf2;
  logic signed [CORR_W-1:0] corr2;
  logic [GAIN_W-1:0]        gain2;
  logic [IDX_W-1:0]         idx2;

  pixcal_cmode #(.AMP_W(AMP_W), .COL_W(COL_W), .REF_N(REF_N), .CORR_W(CORR_W)) u_cm (
    .clk(clk), .rst(rst), .upd(adv && v1), .col(idx1[COL_W-1:0]),
    .amp(amp1), .base(base1), .corr(corr_c), .is_ref(ref_c)
  );

  always_ff @(posedge clk) begin
    if (rst) v2 <= 1'b0;
    else if (adv) v2 <= v1;
    if (adv) begin
      corr2 <= corr_c;
      gain2 <= gain1;
      bad2  <= badf1 || (gsel1 == GC_BAD);
      rf2   <= ref_c;
      idx2  <= idx1;
    end
  end

  // Stage 3: gain scaling
  logic                     v3, bad3, rf3;
  logic signed [PROD_W-1:0] prod3;
  logic [IDX_W-1:0]         idx3;

  always_ff @(posedge clk) begin
    if (rst) v3 <= 1'b0;
    else if (adv) v3 <= v2;
    if (adv) begin
      prod3 <= corr2 * $signed({1'b0, gain2});
      bad3  <= bad2;
      rf3   <= rf2;
      idx3  <= idx2;
    end
  end

  // Stage 4: rounding and registered output
  logic [OUT_W-1:0] word_c;

  pixcal_round #(.CORR_W(CORR_W), .GAIN_W(GAIN_W), .FRAC(FRAC), .OUT_W(OUT_W),
                 .PROD_W(PROD_W)) u_rnd (
    .prod(prod3), .bad(bad3), .is_ref(rf3), .word(word_c)
  );

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else if (adv) out_valid <= v3;
    if (adv) begin
      out_data <= word_c;
      out_idx  <= idx3;
    end
  end
endmodule

// File: rtl/pixcal_chk.sv
module pixcal_chk #(
  parameter int OUT_W = 16,
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             adv,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data,
  input logic [IDX_W-1:0] out_idx,
  input logic             v3,
  input logic             bad3,
  input logic             rf3
);
  localparam logic [OUT_W-1:0] MARKER = '1;

  p_hold_stall_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_idx));

  p_block_input_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  p_ref_zero_r5: assert property (@(posedge clk) disable iff (rst)
    v3 && adv && rf3 |=> out_valid && out_data == '0);

  p_bad_marker_r8: assert property (@(posedge clk) disable iff (rst)
    v3 && adv && bad3 && !rf3 |=> out_valid && out_data == MARKER);

  p_marker_reserved_r7: assert property (@(posedge clk) disable iff (rst)
    v3 && adv && !bad3 && !rf3 |=> out_data != MARKER);

  p_reset_idle_r11: assert property (@(posedge clk)
    $fell(rst) |-> !out_valid && in_ready);
endmodule

bind pixcal_top pixcal_chk #(.OUT_W(OUT_W), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst(rst), .adv(adv), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_idx(out_idx),
  .v3(v3), .bad3(bad3), .rf3(rf3)
);

// File: tb/pixcal_top_tb.sv
module pixcal_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_word = '0;
  logic [7:0]  in_idx = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;
  logic [7:0]  out_idx;
  logic        cal_we = 1'b0, cal_bad_we = 1'b0, cal_bad = 1'b0;
  logic [7:0]  cal_idx = '0;
  logic [1:0]  cal_gsel = '0;
  logic [13:0] cal_base = '0;
  logic [15:0] cal_gain = '0;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  pixcal_top dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_idx(in_idx), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_idx(out_idx), .cal_we(cal_we), .cal_bad_we(cal_bad_we),
    .cal_idx(cal_idx), .cal_gsel(cal_gsel), .cal_base(cal_base), .cal_gain(cal_gain),
    .cal_bad(cal_bad)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cal_write(int idx, int gc, int base, int gain);
    @(negedge clk);
    cal_we = 1'b1; cal_idx = 8'(idx); cal_gsel = 2'(gc);
    cal_base = 14'(base); cal_gain = 16'(gain);
    @(negedge clk);
    cal_we = 1'b0;
  endtask

  task automatic bad_write(int idx, bit b);
    @(negedge clk);
    cal_bad_we = 1'b1; cal_idx = 8'(idx); cal_bad = b;
    @(negedge clk);
    cal_bad_we = 1'b0;
  endtask

  // Drive one pixel; returns on the falling edge after the accepting edge.
  task automatic push(int idx, int gc, int amp);
    @(negedge clk);
    in_valid = 1'b1; in_word = {2'(gc), 14'(amp)}; in_idx = 8'(idx);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Single pixel: due after the third edge following acceptance.
  task automatic pixel(string tag, int idx, int gc, int amp, int exp);
    push(idx, gc, amp);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({tag, " valid"}, int'(out_valid), 1);
    check({tag, " data"}, int'(out_data), exp);
    check({tag, " idx"}, int'(out_idx), idx);
  endtask

  task automatic t_reset();
    check("R11 out_valid after reset", int'(out_valid), 0);
    check("R11 in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_latency();
    // R9: nothing early, result exactly on the third edge after acceptance
    push(4, 0, 300);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9 not valid before due edge", int'(out_valid), 0);
    @(posedge clk);
    @(negedge clk);
    check("R9 valid on due edge", int'(out_valid), 1);
    // R4/R11: offset is 0 before the first latch: 300-100-0 = 200
    check("R4 offset zero after reset", int'(out_data), 200);
  endtask

  task automatic t_refs_row0();
    pixel("R5 ref col0", 0, 0, 110, 0);
    pixel("R5 ref col1", 1, 0, 112, 0);
    pixel("R5 ref col2", 2, 0, 108, 0);
    pixel("R5 ref col3", 3, 0, 113, 0);
  endtask

  task automatic t_gain_codes();
    // offset = floor(43/4) = 10
    pixel("R3 R4 code0", 5, 0, 1234, 1124);
    pixel("R1 code1 table", 5, 1, 1234, 2048);
    pixel("R1 code2 table", 5, 2, 1234, 587);
  endtask

  task automatic t_rounding();
    pixel("R6 1*1.5 half up", 6, 0, 111, 2);
    pixel("R6 1*0.5 half up", 13, 0, 111, 1);
    pixel("R6 3*0.5 half up", 13, 0, 113, 2);
  endtask

  task automatic t_clamp();
    pixel("R7 negative to zero", 15, 0, 50, 0);
    pixel("R7 saturate 65534", 7, 0, 16383, 65534);
  endtask

  task automatic t_bad();
    pixel("R8 bad flag", 8, 0, 500, 65535);
    pixel("R8 gain code 3", 9, 3, 500, 65535);
  endtask

  task automatic t_burst();
    int amps [3] = '{500, 600, 700};
    int exps [3] = '{390, 490, 590};
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_word = {2'd0, 14'(amps[i])}; in_idx = 8'(10 + i);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      @(negedge clk);
      check("R9 burst order idx", int'(out_idx), 10 + i);
      check("R9 burst data", int'(out_data), exps[i]);
    end
  endtask

  task automatic t_rewrite();
    cal_write(10, 0, 100, 8192);
    pixel("R2 rewritten gain", 10, 0, 200, 180);
  endtask

  task automatic t_neg_offset();
    pixel("R5 ref row1 col0", 16, 0, 97, 0);
    pixel("R5 ref row1 col1", 17, 0, 98, 0);
    pixel("R5 ref row1 col2", 18, 0, 98, 0);
    pixel("R5 ref row1 col3", 19, 0, 98, 0);
    // sum -9, floor(-9/4) = -3: 200-100+3
    pixel("R4 negative offset floor", 21, 0, 200, 103);
  endtask

  task automatic t_backpressure();
    logic [15:0] held;
    @(negedge clk);
    out_ready = 1'b0;
    push(22, 0, 300);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R10 valid while stalled", int'(out_valid), 1);
    check("R10 in_ready low while stalled", int'(in_ready), 0);
    check("R10 data while stalled", int'(out_data), 203);
    held = out_data;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 data held", int'(out_data), int'(held));
    check("R10 idx held", int'(out_idx), 22);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R10 drained after release", int'(out_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    for (int p = 0; p < 32; p++) begin
      for (int g = 0; g < 3; g++) cal_write(p, g, 100, 4096);
      bad_write(p, 1'b0);
    end
    cal_write(5, 1, 200, 8192);
    cal_write(5, 2, 50, 2048);
    cal_write(6, 0, 100, 6144);
    cal_write(7, 0, 0, 65535);
    cal_write(13, 0, 100, 2048);
    bad_write(8, 1'b1);
    t_latency();
    t_refs_row0();
    t_gain_codes();
    t_rounding();
    t_clamp();
    t_bad();
    t_burst();
    t_rewrite();
    t_neg_offset();
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule